// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and afterwards keeps the array refreshed. After a configurable hold time it precharges every bank, runs two auto refreshes, and loads the mode register from a word supplied on its input. Each command is followed by a timed gap of NOP cycles. When the sequence is over it raises `ready`, so that an external arbiter may start placing user commands on the shared pins.

Once running, an interval timer produces one refresh obligation every `REF_PERIOD_MS * CLK_KHZ / REF_COUNT` clocks. The block asks the arbiter for a slot with `ref_req`. On `ref_gnt` it takes over the pins for one refresh. If the arbiter reports open rows, it closes them first with a precharge-all. Obligations that cannot be served at once are counted, up to `MAX_PEND`. One more raises a sticky error flag.

`ready` has one meaning: a user command may be placed on the pins in the cycle after a cycle in which `ready` is high. The arbiter must not do so in the cycle after it grants a refresh. Both `ready` and `ref_req` are plain levels. The timer keeps running while a request waits.

Top module: `sdr_boot_refresh`

## Requirements
- R1: While reset is asserted the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), cke and dqm are 1, and ready, ref_req and ref_err are 0.
- R2: After reset is released, the first non-NOP command appears in the STARTUP_CYC-th cycle, and every earlier cycle carries NOP.
- R3: The start-up commands come in this order: precharge-all (0010, with addr bit 10 set), auto refresh (0001), auto refresh, mode register set (0000). Each follows the previous one by exactly TRP_CYC, TRFC_CYC and TRFC_CYC cycles.
- R4: During the mode register set, addr carries mode_word with bits 11 and 10 forced to zero.
- R5: ready is first high TMRD_CYC-1 cycles after the mode register set cycle, so a user command lands at least TMRD_CYC cycles after it. Whenever ready is high, the pins carry NOP.
- R6: cke and dqm stay high through the whole start-up sequence. dqm falls in the cycle after ready first rises, and cke stays high.
- R7: ref_req first rises exactly REF_INTERVAL = REF_PERIOD_MS*CLK_KHZ/REF_COUNT cycles after the mode register set cycle.
- R8: When ref_gnt is seen with ref_req high and rows_open low, an auto refresh appears in the next cycle, and ready returns TRFC_CYC-1 cycles after that refresh.
- R9: When ref_gnt is seen with rows_open high, a precharge-all (addr bit 10 set) appears in the next cycle, and the auto refresh follows TRP_CYC cycles later with NOPs between.
- R10: Obligations that go unserved are counted, up to MAX_PEND. Under a continuous grant, exactly that many refreshes are then issued.
- R11: ref_err rises only when an interval expires with MAX_PEND obligations already queued, and it then stays high until reset.
- R12: An interval expiry in the same cycle as a refresh being taken leaves one obligation outstanding, so ref_req rises again as soon as the refresh gap ends.
- R13: Every command cycle is followed by at least one NOP cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_word | input | ADDR_W | Value programmed into the mode register |
| rows_open | input | 1 | Arbiter reports at least one open row |
| ref_gnt | input | 1 | Arbiter grants the pins for a refresh |
| ref_req | output | 1 | A refresh obligation is waiting for a slot |
| ready | output | 1 | User command allowed on the following cycle |
| ref_err | output | 1 | Sticky: an obligation was lost to a full queue |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus; bit 10 selects all banks on precharge |
| dqm | output | 1 | Data mask, held high during start-up |

## Verification
Two events can land on the same clock edge: the interval timer expiring and a granted refresh consuming an obligation. The bench waits for one pending obligation and withholds the grant. It then asserts the grant in the cycle just before the next expiry, so that the take and the new obligation coincide. The check requires that the refresh appears in the expected cycle and that `ref_req` rises again exactly TRFC_CYC-1 cycles later. A design in which either event overrides the other would stay silent until the following interval.

// File: rtl/sdr_boot_pkg.sv
package sdr_boot_pkg;

  // Pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_t;

  typedef enum logic [2:0] {
    ST_BOOT_PRE,
    ST_BOOT_REF1,
    ST_BOOT_REF2,
    ST_BOOT_MRS,
    ST_RUN,
    ST_RUN_REF
  } seq_state_t;

  localparam int AP_BIT = 10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int INTERVAL = 1562,
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic pend_nz,
  output logic overflow
);
  localparam int CNT_W  = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              ovf_q;
  logic              tick;

  assign tick     = en && (cnt_q == CNT_W'(INTERVAL - 1));
  assign pend_nz  = (pend_q != '0);
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (!en) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      unique case ({tick, take})
        2'b10: begin
          if (pend_q == PEND_W'(MAX_PEND)) ovf_q <= 1'b1;
          else                             pend_q <= pend_q + 1'b1;
        end
        2'b01:   pend_q <= pend_q - 1'b1;
        default: ; // idle, or expiry and take cancel out
      endcase
    end
  end

  p_pend_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(MAX_PEND));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  p_take_needs_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_nz);

  p_tick_leaves_work_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pend_nz);

endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
  import sdr_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
    end else begin
      cmd_q <= cmd_in;
      addr  <= addr_in;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;

  p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> addr[AP_BIT]);

  p_mrs_top_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |-> (addr[11:10] == 2'b00));

  p_nop_after_cmd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdr_boot_refresh.sv
module sdr_boot_refresh
  import sdr_boot_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int STARTUP_CYC   = 20000,
  parameter int TRP_CYC       = 3,
  parameter int TRFC_CYC      = 9,
  parameter int TMRD_CYC      = 2,
  parameter int CLK_KHZ       = 100000,
  parameter int REF_PERIOD_MS = 64,
  parameter int REF_COUNT     = 4096,
  parameter int MAX_PEND      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              rows_open,
  input  logic              ref_gnt,
  output logic              ref_req,
  output logic              ready,
  output logic              ref_err,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              dqm
);
  localparam int REF_INTERVAL = (REF_PERIOD_MS * CLK_KHZ) / REF_COUNT;
  localparam int WAIT_MAX = max2(max2(STARTUP_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  seq_state_t        state_q, state_n;
  logic [WAIT_W-1:0] wcnt_q, wcnt_n;
  cmd_t              cmd_n;
  logic [ADDR_W-1:0] addr_n;
  logic [ADDR_W-1:0] mrs_word;
  logic              take, pend_nz, run_on_q, boot_done_q;

  always_comb begin
    mrs_word        = mode_word;
    mrs_word[11:10] = 2'b00;
  end

  always_comb begin
    state_n = state_q;
    wcnt_n  = wcnt_q;
    cmd_n   = CMD_NOP;
    addr_n  = '0;
    take    = 1'b0;
    if (wcnt_q != '0) begin
      wcnt_n = wcnt_q - 1'b1;
    end else begin
      unique case (state_q)
        ST_BOOT_PRE: begin
          cmd_n          = CMD_PRE;
          addr_n[AP_BIT] = 1'b1;
          wcnt_n         = WAIT_W'(TRP_CYC - 1);
          state_n        = ST_BOOT_REF1;
        end
        ST_BOOT_REF1: begin
          cmd_n   = CMD_REF;
          wcnt_n  = WAIT_W'(TRFC_CYC - 1);
          state_n = ST_BOOT_REF2;
        end
        ST_BOOT_REF2: begin
          cmd_n   = CMD_REF;
          wcnt_n  = WAIT_W'(TRFC_CYC - 1);
          state_n = ST_BOOT_MRS;
        end
        ST_BOOT_MRS: begin
          cmd_n   = CMD_MRS;
          addr_n  = mrs_word;
          wcnt_n  = WAIT_W'(TMRD_CYC - 1);
          state_n = ST_RUN;
        end
        ST_RUN: begin
          if (pend_nz && ref_gnt) begin
            if (rows_open) begin
              cmd_n          = CMD_PRE;
              addr_n[AP_BIT] = 1'b1;
              wcnt_n         = WAIT_W'(TRP_CYC - 1);
              state_n        = ST_RUN_REF;
            end else begin
              cmd_n  = CMD_REF;
              take   = 1'b1;
              wcnt_n = WAIT_W'(TRFC_CYC - 1);
            end
          end
        end
        ST_RUN_REF: begin
          cmd_n   = CMD_REF;
          take    = 1'b1;
          wcnt_n  = WAIT_W'(TRFC_CYC - 1);
          state_n = ST_RUN;
        end
        default: state_n = ST_BOOT_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_BOOT_PRE;
      wcnt_q      <= WAIT_W'(STARTUP_CYC - 1);
      run_on_q    <= 1'b0;
      boot_done_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      wcnt_q      <= wcnt_n;
      run_on_q    <= run_on_q | (state_q == ST_BOOT_MRS && wcnt_q == '0);
      boot_done_q <= boot_done_q | ready;
    end
  end

  assign ready   = (state_q == ST_RUN) && (wcnt_q == '0);
  assign ref_req = ready && pend_nz;
  assign cke     = 1'b1;
  assign dqm     = ~boot_done_q;

  sdr_ref_timer #(
    .INTERVAL (REF_INTERVAL),
    .MAX_PEND (MAX_PEND)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run_on_q),
    .take     (take),
    .pend_nz  (pend_nz),
    .overflow (ref_err)
  );

  sdr_cmd_drive #(
    .ADDR_W (ADDR_W)
  ) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_in  (cmd_n),
    .addr_in (addr_n),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr)
  );

  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  p_boot_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_on_q |-> (cke && dqm && !ready));

endmodule

// File: tb/sdr_boot_refresh_test.sv
`timescale 1ns/1ps
module sdr_boot_refresh_test;
  localparam int AW = 12, SU = 20, TRP = 3, TRFC = 9, TMRD = 2;
  localparam int KHZ = 1600, PMS = 64, RCNT = 1024, MAXP = 8;
  localparam int IV = PMS * KHZ / RCNT; // 100
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, rows_open = 1'b0, ref_gnt = 1'b0;
  logic [AW-1:0] mode_word = 12'hFFF;
  logic ref_req, ready, ref_err, cke, cs_n, ras_n, cas_n, we_n, dqm;
  logic [AW-1:0] addr;
  wire  [3:0] pins = {cs_n, ras_n, cas_n, we_n};

  int tests = 0, fails = 0, cyc = 0, rel = 0, mrs_c = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_boot_refresh #(
    .ADDR_W(AW), .STARTUP_CYC(SU), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
    .CLK_KHZ(KHZ), .REF_PERIOD_MS(PMS), .REF_COUNT(RCNT), .MAX_PEND(MAXP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .rows_open(rows_open),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready), .ref_err(ref_err),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dqm(dqm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req(input int limit);
    for (int i = 0; i < limit && !ref_req; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pins", pins, NOP);
    chk("R1 cke/dqm", {cke, dqm}, 2'b11);
    chk("R1 flags", {ready, ref_req, ref_err}, 0);
    rst_n = 1'b1;
    rel = cyc;
  endtask

  task automatic t_boot;
    int c[4];
    logic [3:0] k[4];
    logic [AW-1:0] a[4];
    int n = 0, bad = 0;
    for (int i = 0; i < 200 && n < 4; i++) begin
      @(negedge clk);
      if (!(cke && dqm)) bad++;
      if (pins != NOP) begin c[n] = cyc; k[n] = pins; a[n] = addr; n++; end
    end
    chk("R3 command count", n, 4);
    chk("R2 first command cycle", c[0] - rel, SU);
    chk("R3 order", {k[0], k[1], k[2], k[3]}, {PRE, REF, REF, MRS});
    chk("R3 precharge all bit", a[0][10], 1);
    chk("R3 gap pre-ref", c[1] - c[0], TRP);
    chk("R3 gap ref-ref", c[2] - c[1], TRFC);
    chk("R3 gap ref-mrs", c[3] - c[2], TRFC);
    chk("R4 mode word", a[3], 12'h3FF);
    chk("R6 cke/dqm low in boot", bad, 0);
    mrs_c = c[3];
  endtask

  task automatic t_ready;
    int extra = 0;
    while (!ready && cyc < mrs_c + 20) begin
      @(negedge clk);
      if (pins != NOP) extra++;
    end
    chk("R5 ready cycle", cyc - mrs_c, TMRD - 1);
    chk("R13 NOP before ready", extra, 0);
    chk("R6 dqm at ready", dqm, 1);
    @(negedge clk);
    chk("R6 dqm after ready", {dqm, cke}, 2'b01);
  endtask

  task automatic t_first_req_closed;
    int r;
    wait_req(300);
    chk("R7 first request", cyc - mrs_c, IV);
    rows_open = 1'b0; ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    r = cyc;
    chk("R8 refresh issued", pins, REF);
    chk("R8 ready low", {ready, ref_req}, 0);
    while (!ready && cyc < r + 40) @(negedge clk);
    chk("R8 ready return", cyc - r, TRFC - 1);
  endtask

  task automatic t_open_rows;
    int p;
    wait_req(300);
    rows_open = 1'b1; ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    p = cyc;
    chk("R9 precharge first", pins, PRE);
    chk("R9 all banks bit", addr[10], 1);
    @(negedge clk);
    while (pins == NOP && cyc < p + 20) @(negedge clk);
    chk("R9 refresh after trp", cyc - p, TRP);
    chk("R9 refresh cmd", pins, REF);
    rows_open = 1'b0;
  endtask

  task automatic drain(input int cycles, output int n);
    n = 0;
    ref_gnt = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pins == REF) n++;
    end
    ref_gnt = 1'b0;
  endtask

  task automatic t_postpone;
    int n;
    wait_req(300);
    repeat (250) @(negedge clk);
    chk("R11 no error at 3", ref_err, 0);
    drain(40, n);
    chk("R10 three queued served", n, 3);
  endtask

  task automatic t_overflow;
    int n;
    wait_req(300);
    repeat (7 * IV + 50) @(negedge clk);
    chk("R11 no error at full queue", ref_err, 0);
    repeat (70) @(negedge clk);
    chk("R11 error on overflow", ref_err, 1);
    drain(75, n);
    chk("R10 queue capped", n, MAXP);
    chk("R11 error sticky", ref_err, 1);
  endtask

  task automatic t_collide;
    int t0;
    wait_req(300);
    t0 = cyc;
    while (cyc < t0 + IV - 1) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk("R12 refresh at expiry edge", pins, REF);
    chk("R12 refresh cycle", cyc - t0, IV);
    repeat (TRFC - 1) @(negedge clk);
    chk("R12 request again", {ready, ref_req}, 2'b11);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_boot;
    t_ready;
    t_first_req_closed;
    t_open_rows;
    t_postpone;
    t_overflow;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule